// File: doc/BRIEF.md
# Two-Stage Black-Level Offset Calibration Controller

This block closes the digital feedback loop that holds the black level of an image-sensor channel at a chosen code. Two offset DACs act on the channel. The coarse DAC sits ahead of the gain stage, and the fine DAC sits after it. Once per line the block receives an averaged black value and a target code. It then updates the two sign-magnitude DAC codes so that the averaged black value moves toward the target. One fine-DAC LSB equals one converter LSB. One coarse-DAC LSB is worth an amount that depends on the gain.

When the correction needed by the fine DAC would go past its ±255 range, the coarse DAC moves exactly one LSB in the direction that reduces the error. The fine DAC then takes up the remainder. For that remainder the block uses an estimate of the coarse step, which it derives from the gain code. Each DAC can instead be programmed directly. When a DAC returns to automatic mode, the loop starts from the code that DAC already holds.

Top module: `ofs_cal_ctrl`

## Requirements
- R1: After reset both DAC codes are +0 (9'h000) and `fine_act` is 0.
- R2: A DAC code is 9 bits. Bit 8 is the sign (1 = negative) and bits 7:0 are the magnitude. An output code is never negative zero, and a programmed 9'h100 appears as 9'h000.
- R3: On an automatic update, let err = avg − target and need = fine − err. If |need| ≤ 255, the fine value becomes need, the coarse code is unchanged and `fine_act` becomes 1.
- R4: In full-auto mode with |need| > 255, the coarse value moves by +1 when need > 0 and by −1 when need < 0. The fine value becomes need minus (dir × step), clamped to ±255, and `fine_act` becomes 0. The coarse value never changes by more than one per update.
- R5: step = min(255, n << (gain_code >> 7)). n is 4 for gain code < 128, 3 for 128–191, 2 for 192–255 and 1 for 256 and above.
- R6: With `fine_first`=1, an out-of-range need first drives the fine value to the limit in its direction (±255, `fine_act`=1) and leaves the coarse value unchanged. The coarse value steps only once the fine value already sits at that limit.
- R7: With `hyst_off`=0, an update whose |err| ≤ 1 changes nothing. With `hyst_off`=1 the update is applied.
- R8: If the coarse value is already at ±255 in the direction required, it stays there, and the fine value becomes need clamped to ±255 with `fine_act`=1.
- R9: Mode decode uses `coarse_byp` and `fine_byp`, where 0 means auto. Both 0 gives full auto. coarse_byp=1 with fine_byp=0 gives fine-only auto: fine = clamp(need), `fine_act`=1, and the coarse code follows `prog_coarse`. fine_byp=1 makes both DACs programmed, and `avg_vld` is then ignored.
- R10: A bypassed DAC shows its programmed code one cycle after the bypass applies. On return to auto, the code it holds is kept as the starting point.
- R11: Codes and `fine_act` change only on a cycle with `avg_vld`=1, or through a bypass load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| avg_vld | input | 1 | One-cycle strobe: new line average available |
| avg_val | input | 10 | Averaged black value (unsigned) |
| target | input | 10 | Desired black code (unsigned) |
| gain_code | input | 10 | Gain-stage code |
| coarse_byp | input | 1 | 1 = coarse DAC directly programmed |
| fine_byp | input | 1 | 1 = fine DAC directly programmed |
| fine_first | input | 1 | 1 = fine DAC saturates before coarse steps |
| hyst_off | input | 1 | 1 = disable the ±1 LSB dead band |
| prog_coarse | input | 9 | Directly programmed coarse code, sign-magnitude |
| prog_fine | input | 9 | Directly programmed fine code, sign-magnitude |
| coarse_code | output | 9 | Coarse DAC code, sign-magnitude |
| fine_code | output | 9 | Fine DAC code, sign-magnitude |
| fine_act | output | 1 | 1 = last update was fine, 0 = last update stepped coarse |

## Verification
The assertions check on every cycle that no code is negative zero and that codes hold when no strobe arrives. They also check that the coarse value moves by at most one per update, that the dead band freezes the fine code, that a bypassed DAC follows its programmed code, and that a coarse move always clears `fine_act`. Only the bench scenarios can show the arithmetic of each update. These cover the residue taken up by the fine DAC for each gain bracket, the fine-first ordering, saturation at the coarse limit, and the retention of codes when a DAC returns from direct programming to auto mode.

// File: rtl/ofs_cal_pkg.sv
package ofs_cal_pkg;
  localparam int MAG_W  = 8;
  localparam int CODE_W = MAG_W + 1;
  localparam int SV_W   = MAG_W + 2;
  localparam int WIDE_W = 16;
  localparam int LIM    = (1 << MAG_W) - 1;

  typedef logic [CODE_W-1:0]        code_t;
  typedef logic signed [SV_W-1:0]   sval_t;
  typedef logic signed [WIDE_W-1:0] wide_t;

  function automatic sval_t sm2s(code_t c);
    sval_t m;
    m = sval_t'({2'b00, c[MAG_W-1:0]});
    return c[CODE_W-1] ? -m : m;
  endfunction

  function automatic code_t s2sm(sval_t v);
    sval_t m;
    if (v < 0) begin
      m = -v;
      return {1'b1, m[MAG_W-1:0]};
    end
    return {1'b0, v[MAG_W-1:0]};
  endfunction

  function automatic code_t sm_norm(code_t c);
    return (c[MAG_W-1:0] == '0) ? '0 : c;
  endfunction

  function automatic sval_t clamp_lim(wide_t x);
    if (x > wide_t'(LIM))  return sval_t'(LIM);
    if (x < -wide_t'(LIM)) return -sval_t'(LIM);
    return sval_t'(x);
  endfunction
endpackage

// File: rtl/ofs_step_est.sv
module ofs_step_est
  import ofs_cal_pkg::*;
#(
  parameter int GAIN_W = 10
) (
  input  logic [GAIN_W-1:0] gain_code,
  output logic [MAG_W-1:0]  step
);
  localparam int SH_LSB = 7;
  localparam int BR1    = 128;
  localparam int BR2    = 192;
  localparam int BR3    = 256;

  logic [2:0]  n_mult;
  logic [31:0] prod;
  logic [GAIN_W-SH_LSB-1:0] sh;

  always_comb begin
    if (int'(gain_code) < BR1)      n_mult = 3'd4;
    else if (int'(gain_code) < BR2) n_mult = 3'd3;
    else if (int'(gain_code) < BR3) n_mult = 3'd2;
    else                            n_mult = 3'd1;
  end

  assign sh   = gain_code[GAIN_W-1:SH_LSB];
  assign prod = 32'(n_mult) << sh;

  always_comb begin
    if (prod > 32'(LIM)) step = MAG_W'(LIM);
    else                 step = prod[MAG_W-1:0];
  end
endmodule

// File: rtl/ofs_err_calc.sv
module ofs_err_calc
  import ofs_cal_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic [DATA_W-1:0] avg_val,
  input  logic [DATA_W-1:0] target,
  input  sval_t             fine_s,
  output wide_t             need,
  output logic              in_range,
  output logic              small_err
);
  wide_t err;

  always_comb begin
    err       = wide_t'(avg_val) - wide_t'(target);
    need      = wide_t'(fine_s) - err;
    small_err = (err >= -wide_t'(1)) && (err <= wide_t'(1));
    in_range  = (need <= wide_t'(LIM)) && (need >= -wide_t'(LIM));
  end
endmodule

// File: rtl/ofs_dac_reg.sv
module ofs_dac_reg
  import ofs_cal_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  byp,
  input  code_t prog,
  input  logic  upd,
  input  sval_t nxt,
  output code_t q
);
  code_t d;
  logic  ld;

  assign ld = byp | upd;

  always_comb begin
    if (byp) d = sm_norm(prog);
    else     d = s2sm(nxt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (ld) q <= d;
  end

  AST_NO_NEG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    q[CODE_W-1] |-> (q[MAG_W-1:0] != '0));  // R2
  AST_BYP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    byp |=> (q == sm_norm($past(prog))));  // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!byp && !upd) |=> $stable(q));  // R11
endmodule

// File: rtl/ofs_cal_ctrl.sv
module ofs_cal_ctrl
  import ofs_cal_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int GAIN_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              avg_vld,
  input  logic [DATA_W-1:0] avg_val,
  input  logic [DATA_W-1:0] target,
  input  logic [GAIN_W-1:0] gain_code,
  input  logic              coarse_byp,
  input  logic              fine_byp,
  input  logic              fine_first,
  input  logic              hyst_off,
  input  logic [8:0]        prog_coarse,
  input  logic [8:0]        prog_fine,
  output logic [8:0]        coarse_code,
  output logic [8:0]        fine_code,
  output logic              fine_act
);
  logic auto_f, auto_c;
  logic c_upd, f_upd, flag_nxt;
  sval_t c_s, f_s, c_nxt, f_nxt, lim_dir;
  wide_t need;
  logic in_range, small_err, dir_pos;
  logic [MAG_W-1:0] step;

  // Coarse auto is only valid with fine auto; fine may run alone
  assign auto_f = !fine_byp;
  assign auto_c = !coarse_byp && !fine_byp;

  assign c_s = sm2s(coarse_code);
  assign f_s = sm2s(fine_code);

  ofs_step_est #(.GAIN_W(GAIN_W)) u_step (
    .gain_code (gain_code),
    .step      (step)
  );

  ofs_err_calc #(.DATA_W(DATA_W)) u_err (
    .avg_val   (avg_val),
    .target    (target),
    .fine_s    (f_s),
    .need      (need),
    .in_range  (in_range),
    .small_err (small_err)
  );

  always_comb begin
    c_upd    = 1'b0;
    f_upd    = 1'b0;
    c_nxt    = c_s;
    f_nxt    = f_s;
    flag_nxt = fine_act;
    dir_pos  = need > 0;
    lim_dir  = dir_pos ? sval_t'(LIM) : -sval_t'(LIM);
    if (avg_vld && auto_f && !(!hyst_off && small_err)) begin
      f_upd    = 1'b1;
      flag_nxt = 1'b1;
      if (!auto_c || in_range) begin
        f_nxt = clamp_lim(need);
      end else if (c_s == lim_dir) begin
        f_nxt = clamp_lim(need);
      end else if (fine_first && (f_s != lim_dir)) begin
        f_nxt = lim_dir;
      end else begin
        c_upd    = 1'b1;
        flag_nxt = 1'b0;
        if (dir_pos) begin
          c_nxt = c_s + sval_t'(1);
          f_nxt = clamp_lim(need - wide_t'(step));
        end else begin
          c_nxt = c_s - sval_t'(1);
          f_nxt = clamp_lim(need + wide_t'(step));
        end
      end
    end
  end

  ofs_dac_reg u_coarse (
    .clk   (clk),
    .rst_n (rst_n),
    .byp   (!auto_c),
    .prog  (prog_coarse),
    .upd   (c_upd),
    .nxt   (c_nxt),
    .q     (coarse_code)
  );

  ofs_dac_reg u_fine (
    .clk   (clk),
    .rst_n (rst_n),
    .byp   (!auto_f),
    .prog  (prog_fine),
    .upd   (f_upd),
    .nxt   (f_nxt),
    .q     (fine_code)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     fine_act <= 1'b0;
    else if (f_upd) fine_act <= flag_nxt;
  end

  AST_COARSE_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    auto_c |=> ((c_s == $past(c_s)) || (c_s == $past(c_s) + sval_t'(1))
               || (c_s == $past(c_s) - sval_t'(1))));  // R4
  AST_COARSE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(auto_c) && !$stable(coarse_code)) |-> !fine_act);  // R4
  AST_HYST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (avg_vld && auto_f && !hyst_off && small_err) |=> $stable(fine_code));  // R7
  AST_NO_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!avg_vld && auto_f) |=> ($stable(fine_code) && $stable(fine_act)));  // R11
endmodule

// File: tb/ofs_cal_ctrl_test.sv
module ofs_cal_ctrl_test;
  logic clk = 1'b0;
  logic rst_n;
  logic avg_vld;
  logic [9:0] avg_val, target, gain_code;
  logic coarse_byp, fine_byp, fine_first, hyst_off;
  logic [8:0] prog_coarse, prog_fine;
  logic [8:0] coarse_code, fine_code;
  logic fine_act;

  int total = 0;
  int bad = 0;
  bit done = 0;
  int mc = 0, mf = 0, mflag = 0;
  logic pend = 1'b0;

  typedef struct { int c; int f; int fl; string tag; } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  ofs_cal_ctrl uut (
    .clk(clk), .rst_n(rst_n), .avg_vld(avg_vld), .avg_val(avg_val),
    .target(target), .gain_code(gain_code), .coarse_byp(coarse_byp),
    .fine_byp(fine_byp), .fine_first(fine_first), .hyst_off(hyst_off),
    .prog_coarse(prog_coarse), .prog_fine(prog_fine),
    .coarse_code(coarse_code), .fine_code(fine_code), .fine_act(fine_act)
  );

  function automatic logic [8:0] sm(int v);
    if (v < 0) return {1'b1, 8'(-v)};
    return {1'b0, 8'(v)};
  endfunction

  function automatic int smv(logic [8:0] c);
    return c[8] ? -int'(c[7:0]) : int'(c[7:0]);
  endfunction

  function automatic int clampv(int x);
    if (x > 255) return 255;
    if (x < -255) return -255;
    return x;
  endfunction

  function automatic int step_of(int g);
    int n, s;
    n = (g < 128) ? 4 : (g < 192) ? 3 : (g < 256) ? 2 : 1;
    s = n << (g >> 7);
    return (s > 255) ? 255 : s;
  endfunction

  task automatic compare(string tag, int c, int f, int fl);
    total++;
    if (coarse_code !== sm(c) || fine_code !== sm(f) || fine_act !== fl[0]) begin
      bad++;
      $display("FAIL %s: actual c=%h f=%h flag=%b expected c=%h f=%h flag=%0d",
               tag, coarse_code, fine_code, fine_act, sm(c), sm(f), fl);
    end
  endtask

  // Driver: applies one line average, pushes the model's expectation
  task automatic drive(string tag, int a, int t, int g);
    int e, nd, dir, lim, stp;
    @(negedge clk);
    avg_val = 10'(a); target = 10'(t); gain_code = 10'(g);
    avg_vld = 1'b1;
    e = a - t;
    stp = step_of(g);
    if (!fine_byp && !(!hyst_off && e >= -1 && e <= 1)) begin
      nd = mf - e;
      mflag = 1;
      if (coarse_byp || (nd <= 255 && nd >= -255)) mf = clampv(nd);
      else begin
        dir = (nd > 0) ? 1 : -1;
        lim = dir * 255;
        if (mc == lim) mf = clampv(nd);
        else if (fine_first && mf != lim) mf = lim;
        else begin
          mc = mc + dir;
          mf = clampv(nd - dir * stp);
          mflag = 0;
        end
      end
    end
    q.push_back('{mc, mf, mflag, tag});
    @(negedge clk);
    avg_vld = 1'b0;
  endtask

  task automatic set_mode(int cb, int fb, logic [8:0] pc, logic [8:0] pf);
    @(negedge clk);
    coarse_byp = cb[0]; fine_byp = fb[0]; prog_coarse = pc; prog_fine = pf;
    if (fb != 0) begin mc = smv(pc); mf = smv(pf); end
    else if (cb != 0) mc = smv(pc);
    @(negedge clk);
  endtask

  always @(posedge clk) pend <= avg_vld;

  // Monitor: pops expectations as results appear
  initial begin
    forever begin
      @(negedge clk);
      if (pend && q.size() > 0) begin
        exp_t x;
        x = q.pop_front();
        compare(x.tag, x.c, x.f, x.fl);
      end
    end
  end

  initial begin
    #100000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; avg_vld = 1'b0; avg_val = '0; target = 10'd64;
    gain_code = '0; coarse_byp = 0; fine_byp = 0; fine_first = 0;
    hyst_off = 0; prog_coarse = '0; prog_fine = '0;
    repeat (3) @(negedge clk);
    compare("R1 reset", 0, 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 after release", 0, 0, 0);

    drive("R3 R2 fine update", 70, 64, 0);           // fine -6 -> 9'h106
    drive("R7 dead band hold", 63, 64, 0);
    @(negedge clk); hyst_off = 1'b1;
    drive("R7 dead band off", 63, 64, 0);            // fine -5
    @(negedge clk); hyst_off = 1'b0;
    repeat (4) @(negedge clk);
    compare("R11 no strobe hold", 0, -5, 1);
    drive("R4 R5 coarse step gain0", 464, 64, 0);    // c -1, f -255
    drive("R5 gain bracket 160", 67, 64, 160);       // step 6: f -252
    drive("R5 gain code 900", 74, 64, 900);          // step 128: f -134
    @(negedge clk); fine_first = 1'b1;
    drive("R6 fine first pins fine", 264, 64, 900);  // f -255, c held
    drive("R6 then coarse steps", 69, 64, 900);      // c -4, f -132
    @(negedge clk); fine_first = 1'b0;
    set_mode(1, 0, 9'h0FF, 9'h000);
    compare("R9 R10 coarse follows prog", 255, -132, 0);
    drive("R9 fine-only auto", 464, 64, 0);          // f -255 flag 1
    set_mode(0, 1, 9'h110, 9'h003);
    compare("R9 both programmed", -16, 3, 1);
    drive("R9 strobe ignored", 100, 64, 0);
    set_mode(0, 1, 9'h110, 9'h100);
    compare("R2 neg zero normalised", -16, 0, 1);
    set_mode(1, 0, 9'h0FF, 9'h100);
    set_mode(0, 0, 9'h0FF, 9'h100);
    repeat (2) @(negedge clk);
    compare("R10 retained on return", 255, 0, 1);
    drive("R8 coarse at limit", 100, 500, 0);        // f 255, c 255
    drive("R4 R5 gain bracket 200", 576, 64, 200);   // c 254, f -253
    repeat (3) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule